// File: doc/BRIEF.md
# MSI-X interrupt vector dispatcher

This block sits between the interrupt sources of a device function and the logic that writes MSI-X messages. It holds one vector register for configuration-change events and one for each of `NUM_QUEUES` queues. When a source raises a request, the block looks up that source's vector. If no vector is assigned, or the vector lies outside the table, the request is dropped. If the function-wide mask or the selected entry's mask is set, the vector's pending bit is set instead of sending a message. Otherwise the vector index goes out on a valid/ready message request.

The block keeps the pending bit array and one mask bit per table entry. When a mask is lifted while a pending bit is set, it replays the message and clears the pending bit. The address and data of a message are left to a downstream writer, which receives only the vector index. Each source keeps at most one request outstanding. Sources are served in a fixed order, lowest index first: the configuration source is index 0 and queue q is index q+1.

Top module: `irq_vec_dispatch`

## Requirements
- R1: After reset every vector register reads as "no vector" (0xFFFF), every pending bit is 0, every entry mask bit is 1 (masked) and `msg_valid_o` is 0.
- R2: A configuration request (`cfg_irq_i`) uses vector register 0 and a request on `q_irq_i[q]` uses vector register q+1, both written through `vec_wr_*`. When the output is free and the vector is unmasked, `msg_valid_o` is high with `msg_vec_o` equal to the vector at the first clock edge that samples the request.
- R3: A request whose vector register holds 0xFFFF produces no message and sets no pending bit, whether or not a mask is set.
- R4: A request whose vector is at or above `NUM_VEC` is dropped in the same way as 0xFFFF. `msg_vec_o` is always below `NUM_VEC` while valid.
- R5: When `func_mask_i` is 1 or the selected entry's mask bit is 1, the request produces no message and sets the pending bit of its vector at the edge that samples it.
- R6: When a vector's pending bit is set and neither the function mask nor its entry mask is set, a message for that vector is loaded at the next free edge and the pending bit clears at that same edge. Among several such vectors the lowest index goes first.
- R7: While `msg_valid_o` is 1 and `msg_ready_i` is 0, `msg_valid_o` stays 1 and `msg_vec_o` stays unchanged.
- R8: Each source holds at most one outstanding request. Requests from one source that arrive while it waits merge into a single message. Waiting sources are served lowest index first, one per edge.
- R9: `pba_rdata_o` bit j shows the pending bit of vector `pba_word_i*32 + j`, and reads 0 where that index is at or above `NUM_VEC`.
- R10: When a source request and a pending replay compete for a free output at the same edge, the source request is loaded and the replay follows at a later free edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vec_wr_i | input | 1 | Write strobe for a vector register |
| vec_wr_idx_i | input | $clog2(NUM_QUEUES+1) | Vector register index: 0 = configuration, q+1 = queue q |
| vec_wr_data_i | input | 16 | Vector value; 0xFFFF = none |
| emask_wr_i | input | 1 | Write strobe for an entry mask bit |
| emask_idx_i | input | $clog2(NUM_VEC) | Table entry whose mask is written |
| emask_val_i | input | 1 | New mask value, 1 = masked |
| func_mask_i | input | 1 | Function-wide mask |
| cfg_irq_i | input | 1 | Configuration-change request pulse |
| q_irq_i | input | NUM_QUEUES | Per-queue request pulses |
| msg_valid_o | output | 1 | Message request valid |
| msg_vec_o | output | $clog2(NUM_VEC) | Vector index of the message |
| msg_ready_i | input | 1 | Downstream accepts the message |
| pba_word_i | input | max(1,$clog2(ceil(NUM_VEC/32))) | Pending array word select |
| pba_rdata_o | output | 32 | Selected 32 pending bits |

## Verification
A request driven before an edge shows its effect at that edge, so the bench samples at the falling edge that follows: the message or the new pending bit, or the lack of both for a dropped vector. A mask write or mask clear takes effect at one edge, and the replayed message with its cleared pending bit appears at the next free edge. The bench therefore checks one sample with the bit still set, then one with the message. Under back-pressure the bench holds ready low for several sampled cycles and then checks the drained messages one per cycle, in priority order. The pending read port is combinational, so it is read a fraction of a cycle after its select changes, always before the next rising edge.

// File: rtl/irq_disp_pkg.sv
`timescale 1ns/1ps
package irq_disp_pkg;
  typedef logic [15:0] vec_t;
  localparam vec_t NO_VECTOR = 16'hFFFF;
  localparam int   PBA_DW    = 32;
endpackage

// File: rtl/irq_prio_pick.sv
`timescale 1ns/1ps
// lowest set bit wins
module irq_prio_pick #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        found_o = 1'b1;
        idx_o   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_vec_regs.sv
`timescale 1ns/1ps
module irq_vec_regs
  import irq_disp_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int SRC_W   = $clog2(NUM_SRC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SRC_W-1:0] wr_idx_i,
  input  vec_t             wr_data_i,
  output vec_t             vec_o [NUM_SRC]
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             vec_o[s] <= NO_VECTOR;
      else if (wr_i && wr_idx_i == SRC_W'(s)) vec_o[s] <= wr_data_i;
    end
  end
endmodule

// File: rtl/irq_pend_table.sv
`timescale 1ns/1ps
module irq_pend_table #(
  parameter int NUM_VEC = 8,
  parameter int VI_W    = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               func_mask_i,
  input  logic               mwr_i,
  input  logic [VI_W-1:0]    midx_i,
  input  logic               mval_i,
  input  logic               set_i,
  input  logic [VI_W-1:0]    set_idx_i,
  input  logic               clr_i,
  input  logic [VI_W-1:0]    clr_idx_i,
  output logic [NUM_VEC-1:0] pba_o,
  output logic [NUM_VEC-1:0] mask_o,
  output logic [NUM_VEC-1:0] cand_o
);
  for (genvar v = 0; v < NUM_VEC; v++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mask_o[v] <= 1'b1;
      else if (mwr_i && midx_i == VI_W'(v))   mask_o[v] <= mval_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               pba_o[v] <= 1'b0;
      else if (set_i && set_idx_i == VI_W'(v))   pba_o[v] <= 1'b1;
      else if (clr_i && clr_idx_i == VI_W'(v))   pba_o[v] <= 1'b0;
    end
  end

  // pending and fully unmasked: eligible for replay
  assign cand_o = pba_o & ~mask_o & {NUM_VEC{~func_mask_i}};
endmodule

// File: rtl/irq_vec_dispatch.sv
`timescale 1ns/1ps
module irq_vec_dispatch
  import irq_disp_pkg::*;
#(
  parameter int  NUM_QUEUES = 4,
  parameter int  NUM_VEC    = 8,
  localparam int NUM_SRC    = NUM_QUEUES + 1,
  localparam int SRC_W      = $clog2(NUM_SRC),
  localparam int VI_W       = $clog2(NUM_VEC),
  localparam int PBA_WORDS  = (NUM_VEC + PBA_DW - 1) / PBA_DW,
  localparam int WSEL_W     = (PBA_WORDS > 1) ? $clog2(PBA_WORDS) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vec_wr_i,
  input  logic [SRC_W-1:0]      vec_wr_idx_i,
  input  logic [15:0]           vec_wr_data_i,
  input  logic                  emask_wr_i,
  input  logic [VI_W-1:0]       emask_idx_i,
  input  logic                  emask_val_i,
  input  logic                  func_mask_i,
  input  logic                  cfg_irq_i,
  input  logic [NUM_QUEUES-1:0] q_irq_i,
  output logic                  msg_valid_o,
  output logic [VI_W-1:0]       msg_vec_o,
  input  logic                  msg_ready_i,
  input  logic [WSEL_W-1:0]     pba_word_i,
  output logic [PBA_DW-1:0]     pba_rdata_o
);
  localparam vec_t VEC_LIMIT = vec_t'(NUM_VEC);

  vec_t               vec_tab [NUM_SRC];
  logic [NUM_SRC-1:0] req_q, req_all, req_clr;
  logic               src_found, sel_ok, sel_masked, out_free;
  logic               src_done, src_load, pba_set;
  logic [SRC_W-1:0]   src_idx;
  vec_t               sel_vec;
  logic [VI_W-1:0]    sel_vidx, rp_idx;
  logic               rp_found, rp_load;
  logic [NUM_VEC-1:0] pba_w, mask_w, cand_w;

  irq_vec_regs #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(vec_wr_i), .wr_idx_i(vec_wr_idx_i), .wr_data_i(vec_wr_data_i),
    .vec_o(vec_tab)
  );

  // new pulses merge with waiting requests: one per source
  assign req_all = req_q | {q_irq_i, cfg_irq_i};

  irq_prio_pick #(.W(NUM_SRC), .IW(SRC_W)) u_src_pick (
    .req_i(req_all), .found_o(src_found), .idx_o(src_idx)
  );

  assign sel_vec    = vec_tab[src_idx];
  assign sel_vidx   = sel_vec[VI_W-1:0];
  assign sel_ok     = (sel_vec != NO_VECTOR) && (sel_vec < VEC_LIMIT);
  assign sel_masked = func_mask_i || (sel_ok && mask_w[sel_vidx]);
  assign out_free   = !msg_valid_o || msg_ready_i;

  assign src_load = src_found && sel_ok && !sel_masked && out_free;
  assign pba_set  = src_found && sel_ok && sel_masked;
  assign src_done = src_found && (!sel_ok || sel_masked || out_free);
  assign req_clr  = src_done ? (NUM_SRC'(1) << src_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_all & ~req_clr;
  end

  irq_prio_pick #(.W(NUM_VEC), .IW(VI_W)) u_rp_pick (
    .req_i(cand_w), .found_o(rp_found), .idx_o(rp_idx)
  );

  assign rp_load = rp_found && out_free && !src_load;

  irq_pend_table #(.NUM_VEC(NUM_VEC), .VI_W(VI_W)) u_pend (
    .clk_i, .rst_ni,
    .func_mask_i,
    .mwr_i(emask_wr_i), .midx_i(emask_idx_i), .mval_i(emask_val_i),
    .set_i(pba_set), .set_idx_i(sel_vidx),
    .clr_i(rp_load), .clr_idx_i(rp_idx),
    .pba_o(pba_w), .mask_o(mask_w), .cand_o(cand_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_valid_o <= 1'b0;
      msg_vec_o   <= '0;
    end else if (src_load) begin
      msg_valid_o <= 1'b1;
      msg_vec_o   <= sel_vidx;
    end else if (rp_load) begin
      msg_valid_o <= 1'b1;
      msg_vec_o   <= rp_idx;
    end else if (msg_ready_i) begin
      msg_valid_o <= 1'b0;
    end
  end

  always_comb begin
    pba_rdata_o = '0;
    for (int j = 0; j < PBA_DW; j++) begin
      if (int'(pba_word_i) * PBA_DW + j < NUM_VEC)
        pba_rdata_o[j] = pba_w[int'(pba_word_i) * PBA_DW + j];
    end
  end
endmodule

// File: rtl/irq_vec_dispatch_chk.sv
`timescale 1ns/1ps
module irq_vec_dispatch_chk #(
  parameter int NUM_VEC = 8,
  parameter int VI_W    = $clog2(NUM_VEC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               msg_valid_o,
  input logic [VI_W-1:0]    msg_vec_o,
  input logic               msg_ready_i,
  input logic               func_mask_i,
  input logic [NUM_VEC-1:0] pba_i
);
  localparam logic [VI_W:0] LIMIT = (VI_W + 1)'(NUM_VEC);

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_vec_o));

  assert_vec_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> {1'b0, msg_vec_o} < LIMIT);

  assert_no_msg_masked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(msg_valid_o) |-> !$past(func_mask_i));

  assert_pend_one_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pba_i) <= $countones($past(pba_i)) + 1);

  assert_clear_sends_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(pba_i) < $countones($past(pba_i)) |-> msg_valid_o);
endmodule

bind irq_vec_dispatch irq_vec_dispatch_chk #(.NUM_VEC(NUM_VEC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .msg_valid_o(msg_valid_o),
  .msg_vec_o(msg_vec_o), .msg_ready_i(msg_ready_i),
  .func_mask_i(func_mask_i), .pba_i(pba_w)
);

// File: tb/irq_vec_dispatch_tb.sv
`timescale 1ns/1ps
module irq_vec_dispatch_tb;
  localparam int NQ = 4;
  localparam int NV = 40;
  localparam int NS = NQ + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic vec_wr_i = 0, emask_wr_i = 0, emask_val_i = 0, func_mask_i = 0;
  logic [2:0]  vec_wr_idx_i = '0;
  logic [15:0] vec_wr_data_i = '0;
  logic [5:0]  emask_idx_i = '0;
  logic cfg_irq_i = 0;
  logic [NQ-1:0] q_irq_i = '0;
  logic msg_valid_o, msg_ready_i = 1'b1;
  logic [5:0] msg_vec_o;
  logic [0:0] pba_word_i = '0;
  logic [31:0] pba_rdata_o;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  irq_vec_dispatch #(.NUM_QUEUES(NQ), .NUM_VEC(NV)) u_dut (.*);

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk_i); endtask

  task automatic set_vec(input int idx, input int val);
    vec_wr_i = 1; vec_wr_idx_i = 3'(idx); vec_wr_data_i = 16'(val);
    cyc(); vec_wr_i = 0;
  endtask

  task automatic set_mask(input int v, input bit m);
    emask_wr_i = 1; emask_idx_i = 6'(v); emask_val_i = m;
    cyc(); emask_wr_i = 0;
  endtask

  task automatic pulse(input logic [NS-1:0] m);
    cfg_irq_i = m[0]; q_irq_i = m[NS-1:1];
    cyc(); cfg_irq_i = 0; q_irq_i = '0;
  endtask

  task automatic rd_pba(input int w, output int val);
    pba_word_i = 1'(w); #0.1; val = int'(pba_rdata_o);
  endtask

  task automatic chk_msg(input string tag, input bit v, input int vec);
    chk({tag, " valid"}, int'(msg_valid_o), int'(v));
    if (v) chk({tag, " vec"}, int'(msg_vec_o), vec);
  endtask

  task automatic chk_pba(input string tag, input int w0, input int w1);
    int r;
    rd_pba(0, r); chk({tag, " pba0"}, r, w0);
    rd_pba(1, r); chk({tag, " pba1"}, r, w1);
  endtask

  task automatic t_reset();
    chk_msg("R1 idle", 0, 0);
    chk_pba("R1 clear", 0, 0);
    pulse(5'b00001);
    chk_msg("R1 no vector at reset", 0, 0);
    chk_pba("R1 no vector pend", 0, 0);
    set_vec(0, 3);
    pulse(5'b00001);
    chk_msg("R1 entry masked at reset", 0, 0);
    chk_pba("R1 pend set", 8, 0);
    set_mask(3, 0);
    chk_msg("R6 before replay", 0, 0);
    chk_pba("R6 still pending", 8, 0);
    cyc();
    chk_msg("R6 replay", 1, 3);
    chk_pba("R6 cleared", 0, 0);
    cyc();
    chk_msg("R6 one message", 0, 0);
  endtask

  task automatic t_cfg_basic();
    pulse(5'b00001);
    chk_msg("R2 cfg", 1, 3);
    cyc();
    chk_msg("R2 cfg done", 0, 0);
  endtask

  task automatic t_queue_sel();
    set_vec(3, 7); set_mask(7, 0);
    set_vec(1, 9); set_mask(9, 0);
    pulse(5'b01000);
    chk_msg("R2 queue2", 1, 7);
    pulse(5'b00010);
    chk_msg("R2 queue0", 1, 9);
    cyc();
  endtask

  task automatic t_drop();
    pulse(5'b00100);
    chk_msg("R3 drop", 0, 0);
    func_mask_i = 1;
    pulse(5'b00100);
    chk_msg("R3 drop masked", 0, 0);
    cyc();
    chk_pba("R3 no pend", 0, 0);
    func_mask_i = 0;
  endtask

  task automatic t_range();
    set_vec(4, 40);
    pulse(5'b10000);
    chk_msg("R4 out of range", 0, 0);
    cyc();
    chk_pba("R4 no pend", 0, 0);
    set_vec(4, 39); set_mask(39, 0);
    pulse(5'b10000);
    chk_msg("R4 top vector", 1, 39);
    cyc();
  endtask

  task automatic t_mask();
    func_mask_i = 1;
    pulse(5'b00001);
    chk_msg("R5 func mask", 0, 0);
    chk_pba("R5 pend cfg", 8, 0);
    pulse(5'b01000);
    chk_pba("R5 pend q2", 136, 0);
    func_mask_i = 0;
    cyc();
    chk_msg("R6 replay low", 1, 3);
    chk_pba("R6 left", 128, 0);
    cyc();
    chk_msg("R6 replay next", 1, 7);
    chk_pba("R6 empty", 0, 0);
    cyc();
    chk_msg("R6 idle", 0, 0);
  endtask

  task automatic t_backpressure();
    msg_ready_i = 0;
    pulse(5'b00001);
    chk_msg("R7 first", 1, 3);
    pulse(5'b00011);
    pulse(5'b00001);
    cyc();
    chk_msg("R7 held", 1, 3);
    cyc();
    chk_msg("R7 held again", 1, 3);
    msg_ready_i = 1;
    cyc();
    chk_msg("R8 cfg merged", 1, 3);
    cyc();
    chk_msg("R8 queue0 next", 1, 9);
    cyc();
    chk_msg("R8 no extra", 0, 0);
  endtask

  task automatic t_priority();
    func_mask_i = 1;
    pulse(5'b01000);
    chk_pba("R10 pend q2", 128, 0);
    func_mask_i = 0;
    pulse(5'b00001);
    chk_msg("R10 source first", 1, 3);
    chk_pba("R10 replay waits", 128, 0);
    cyc();
    chk_msg("R10 replay after", 1, 7);
    chk_pba("R10 cleared", 0, 0);
    cyc();
  endtask

  task automatic t_pba_word();
    set_mask(9, 1);
    pulse(5'b00010);
    chk_msg("R5 entry mask", 0, 0);
    chk_pba("R9 bit9", 512, 0);
    func_mask_i = 1;
    pulse(5'b10000);
    chk_pba("R9 word1 bit7", 512, 128);
    func_mask_i = 0;
    cyc();
    chk_msg("R6 replay 39", 1, 39);
    chk_pba("R6 9 still masked", 512, 0);
    set_mask(9, 0);
    chk_msg("R6 gap", 0, 0);
    cyc();
    chk_msg("R6 replay 9", 1, 9);
    chk_pba("R9 all clear", 0, 0);
    cyc();
  endtask

  initial begin
    repeat (3) cyc();
    rst_ni = 1;
    cyc();
    t_reset();
    t_cfg_basic();
    t_queue_sel();
    t_drop();
    t_range();
    t_mask();
    t_backpressure();
    t_priority();
    t_pba_word();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule